// File: doc/BRIEF.md
# Overlapped Coprocessor Dialog Sequencer

This block is the host-facing side of a floating-point coprocessor that can keep two instructions in flight. A command write from the host places an instruction into a conversion stage, which holds it until the arithmetic stage is free. While it waits, every read of the response word returns a null primitive that keeps the host in step. The arithmetic stage is a stand-in: a down-counter with a per-command latency and a per-command injected exception flag with a vector number.

An exception raised in the arithmetic stage is not reported to the instruction that caused it. It is held pending and reported to the next instruction's dialog as a take-mid-instruction-exception primitive. Reading that primitive clears the pending exception and discards the held instruction.

A context save waits until the arithmetic stage is idle. It then produces a format word made of the version number and the frame length. A restore checks that word against the block's own version and refuses anything it does not recognise. The body of a busy frame is kept in an internal shadow captured by the last save.

Top module: `cop_dialog_seq`

## Requirements
- R1: After reset the response word is 16'h0001, `au_busy` and `slot_full` are 0, and `fmt_err` and `save_done` are 0.
- R2: Response word layout: bit 15 is come-again, bit 14 is PC, bit 13 is DR, bits 12:8 are the function code and bits 7:0 are the low byte. A null primitive has function code 0 and carries interrupts-allowed in bit 0. When no instruction is held and no save is waiting, the response is 16'h0001.
- R3: A command write sets `slot_full` one cycle later. A command write while `slot_full` is 1 is ignored.
- R4: A held instruction is handed to the arithmetic stage at the first clock edge at which that stage is idle, no exception is pending and no save is waiting. `au_busy` then stays 1 for exactly max(latency,1) cycles.
- R5: While an instruction is held, the response is 16'h0000 (CA=0, IA=0). Reading it does not change the held instruction or the pending exception.
- R6: An exception from the arithmetic stage becomes pending. The response stays 16'h0001 until a next instruction is held. From then on the response is 16'h5D00 | vector (PC=1, function code 5'h1D), and hand-off is blocked.
- R7: Reading the take-mid-instruction primitive clears the pending exception and discards the held instruction. The next response is 16'h0001, and the arithmetic stage stays idle.
- R8: A save request completes at the first edge at which the arithmetic stage is idle. `save_done` pulses for one cycle after that edge. Until then, responses are 16'h0000 and hand-off is blocked.
- R9: The saved format word is {version, length}. It is 16'h0000 (null) if no command has been accepted since reset or a null restore. The length is 12 if an instruction is held or an exception is pending, and 4 otherwise.
- R10: A restore accepts only 16'h0000, {version, 8'd4} and {version, 8'd12}. Any other word raises `fmt_err` for one cycle and leaves the response, the held instruction and the pending exception unchanged.
- R11: A null or idle restore empties both stages and clears any pending exception. A following save then yields 16'h0000 or {version, 8'd4} respectively.
- R12: A busy restore reinstates the held instruction and the pending exception captured by the last save. Hand-off then follows under R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_lat | input | LAT_W | Arithmetic latency of the command |
| cmd_exc | input | 1 | Command raises an exception when it completes |
| cmd_vec | input | 8 | Exception vector number of the command |
| resp_rd | input | 1 | Host read of the response word |
| resp_word | output | 16 | Current handshake primitive |
| save_req | input | 1 | Context save request |
| save_done | output | 1 | One-cycle save completion pulse |
| save_fmt | output | 16 | Format word of the last save |
| rest_req | input | 1 | Context restore strobe |
| rest_fmt | input | 16 | Format word supplied with the restore |
| fmt_err | output | 1 | One-cycle restore rejection pulse |
| au_busy | output | 1 | Arithmetic stage executing |
| slot_full | output | 1 | Converted instruction waiting for hand-off |

## Verification
A lost or stale pending exception shows up at the response word. It appears in the very cycle the next instruction is held: a take-mid word where a null was due, or the reverse. A hand-off taken too early or too late shows as a busy window that starts off the expected edge or lasts a wrong number of cycles. A miscaptured shadow shows on the first busy restore, as a wrong `slot_full` or response on the next cycle. A wrong frame classification shows directly in `save_fmt` on the `save_done` cycle.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int VEC_W  = 8;
  localparam int RESP_W = 16;

  localparam logic [4:0] FC_NULL     = 5'h00;
  localparam logic [4:0] FC_TAKE_MID = 5'h1D;

  localparam logic [7:0] LEN_IDLE = 8'd4;
  localparam logic [7:0] LEN_BUSY = 8'd12;

  // null primitive: CA=0, PC=0, DR=0, interrupts-allowed in bit 0
  function automatic logic [RESP_W-1:0] prim_null(input logic ia);
    return {1'b0, 1'b0, 1'b0, FC_NULL, 7'd0, ia};
  endfunction

  function automatic logic [RESP_W-1:0] prim_take_mid(input logic [VEC_W-1:0] vec);
    return {1'b0, 1'b1, 1'b0, FC_TAKE_MID, vec};
  endfunction

  function automatic logic [RESP_W-1:0] fmt_word(input logic [7:0] ver, input logic [7:0] len);
    return {ver, len};
  endfunction
endpackage

// File: rtl/cop_au_timer.sv
module cop_au_timer #(
  parameter int LAT_W = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start,
  input  logic [LAT_W-1:0] lat,
  input  logic             exc,
  input  logic [VEC_W-1:0] vec,
  output logic             busy,
  output logic             done,
  output logic             done_exc,
  output logic [VEC_W-1:0] done_vec
);
  logic [LAT_W-1:0] cnt;
  logic             exc_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      exc_q <= 1'b0;
      vec_q <= '0;
    end else if (kill) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= (lat == '0) ? LAT_W'(1) : lat;
      exc_q <= exc;
      vec_q <= vec;
    end else if (busy) begin
      if (cnt == LAT_W'(1)) busy <= 1'b0;
      else                  cnt  <= cnt - LAT_W'(1);
    end
  end

  assign done     = busy && (cnt == LAT_W'(1)) && !kill;
  assign done_exc = done && exc_q;
  assign done_vec = vec_q;
endmodule

// File: rtl/cop_hold_slot.sv
module cop_hold_slot #(
  parameter int LAT_W = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] in_lat,
  input  logic             in_exc,
  input  logic [VEC_W-1:0] in_vec,
  input  logic             take,
  input  logic             drop,
  input  logic             put,
  input  logic             put_valid,
  input  logic [LAT_W-1:0] put_lat,
  input  logic             put_exc,
  input  logic [VEC_W-1:0] put_vec,
  output logic             valid,
  output logic [LAT_W-1:0] lat,
  output logic             exc,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      lat   <= '0;
      exc   <= 1'b0;
      vec   <= '0;
    end else if (put) begin
      valid <= put_valid;
      lat   <= put_lat;
      exc   <= put_exc;
      vec   <= put_vec;
    end else if (take || drop) begin
      valid <= 1'b0;
    end else if (load && !valid) begin
      valid <= 1'b1;
      lat   <= in_lat;
      exc   <= in_exc;
      vec   <= in_vec;
    end
  end
endmodule

// File: rtl/cop_dialog_seq.sv
module cop_dialog_seq
  import cop_pkg::*;
#(
  parameter int         LAT_W   = 4,
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [LAT_W-1:0] cmd_lat,
  input  logic             cmd_exc,
  input  logic [7:0]       cmd_vec,
  input  logic             resp_rd,
  output logic [15:0]      resp_word,
  input  logic             save_req,
  output logic             save_done,
  output logic [15:0]      save_fmt,
  input  logic             rest_req,
  input  logic [15:0]      rest_fmt,
  output logic             fmt_err,
  output logic             au_busy,
  output logic             slot_full
);
  logic             slot_valid, slot_exc;
  logic [LAT_W-1:0] slot_lat;
  logic [VEC_W-1:0] slot_vec;
  logic             au_done, au_done_exc;
  logic [VEC_W-1:0] au_done_vec;
  logic             pend_exc, save_pend, inited;
  logic [VEC_W-1:0] pend_vec;
  logic             sh_valid, sh_exc, sh_pend;
  logic [LAT_W-1:0] sh_lat;
  logic [VEC_W-1:0] sh_vec, sh_pvec;

  // named events for the checker
  logic rest_null, rest_idle, rest_busy, rest_ok, rest_bad;
  logic save_go, handoff, exc_read;
  logic [15:0] frame_fmt;

  always_comb begin
    rest_null = rest_req && (rest_fmt == 16'h0000);
    rest_idle = rest_req && (rest_fmt == fmt_word(VERSION, LEN_IDLE));
    rest_busy = rest_req && (rest_fmt == fmt_word(VERSION, LEN_BUSY));
    rest_ok   = rest_null || rest_idle || rest_busy;
    rest_bad  = rest_req && !rest_ok;
    save_go   = (save_req || save_pend) && !au_busy && !rest_ok;
    handoff   = slot_valid && !au_busy && !pend_exc && !save_req && !save_pend && !rest_ok;
    exc_read  = resp_rd && slot_valid && pend_exc && !rest_ok;
    if (!inited)                    frame_fmt = 16'h0000;
    else if (slot_valid || pend_exc) frame_fmt = fmt_word(VERSION, LEN_BUSY);
    else                             frame_fmt = fmt_word(VERSION, LEN_IDLE);
  end

  always_comb begin
    if (pend_exc && slot_valid)     resp_word = prim_take_mid(pend_vec);
    else if (slot_valid || save_pend) resp_word = prim_null(1'b0);
    else                             resp_word = prim_null(1'b1);
  end

  cop_hold_slot #(.LAT_W(LAT_W), .VEC_W(VEC_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(cmd_wr && !rest_ok), .in_lat(cmd_lat), .in_exc(cmd_exc), .in_vec(cmd_vec),
    .take(handoff), .drop(exc_read),
    .put(rest_ok), .put_valid(rest_busy && sh_valid),
    .put_lat(sh_lat), .put_exc(sh_exc), .put_vec(sh_vec),
    .valid(slot_valid), .lat(slot_lat), .exc(slot_exc), .vec(slot_vec)
  );

  cop_au_timer #(.LAT_W(LAT_W), .VEC_W(VEC_W)) u_au (
    .clk(clk), .rst_n(rst_n), .kill(rest_ok), .start(handoff),
    .lat(slot_lat), .exc(slot_exc), .vec(slot_vec),
    .busy(au_busy), .done(au_done), .done_exc(au_done_exc), .done_vec(au_done_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_exc  <= 1'b0;
      pend_vec  <= '0;
      save_pend <= 1'b0;
      save_done <= 1'b0;
      save_fmt  <= '0;
      fmt_err   <= 1'b0;
      inited    <= 1'b0;
      sh_valid  <= 1'b0;
      sh_lat    <= '0;
      sh_exc    <= 1'b0;
      sh_vec    <= '0;
      sh_pend   <= 1'b0;
      sh_pvec   <= '0;
    end else begin
      fmt_err   <= rest_bad;
      save_done <= save_go;
      if (rest_ok) begin
        pend_exc <= rest_busy && sh_pend;
        pend_vec <= sh_pvec;
      end else if (au_done_exc) begin
        pend_exc <= 1'b1;
        pend_vec <= au_done_vec;
      end else if (exc_read) begin
        pend_exc <= 1'b0;
      end
      if (rest_ok || save_go) save_pend <= 1'b0;
      else if (save_req)      save_pend <= 1'b1;
      if (save_go) begin
        save_fmt <= frame_fmt;
        sh_valid <= slot_valid;
        sh_lat   <= slot_lat;
        sh_exc   <= slot_exc;
        sh_vec   <= slot_vec;
        sh_pend  <= pend_exc;
        sh_pvec  <= pend_vec;
      end
      if (rest_null)                   inited <= 1'b0;
      else if (rest_idle || rest_busy) inited <= 1'b1;
      else if (cmd_wr && !slot_valid)  inited <= 1'b1;
    end
  end

  assign slot_full = slot_valid;
endmodule

// File: rtl/cop_dialog_chk.sv
module cop_dialog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        resp_rd,
  input logic [15:0] resp_word,
  input logic        save_req,
  input logic        save_done,
  input logic        rest_req,
  input logic        fmt_err,
  input logic        au_busy,
  input logic        slot_valid,
  input logic        pend_exc,
  input logic        handoff,
  input logic        au_done,
  input logic        au_done_exc
);
  // R4
  handoff_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> au_busy && !slot_valid);

  // R6
  exc_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    au_done_exc && !rest_req |=> pend_exc);

  // R6
  exc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_exc && slot_valid && !resp_rd && !rest_req |=> slot_valid && !au_busy);

  // R7
  exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rd && (resp_word[12:8] == 5'h1D) && !rest_req |=> !pend_exc && !slot_valid);

  // R8
  save_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_done |-> !$past(au_busy));

  // R10
  fmt_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> $past(rest_req));

  // R10
  fmt_err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err && !$past(au_done) |-> $stable(slot_valid) && $stable(pend_exc));

  // R5
  null_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rd && (resp_word == 16'h0000) && !cmd_wr && !rest_req && !save_req && !au_done && !handoff
    |=> $stable(slot_valid) && $stable(pend_exc));
endmodule

bind cop_dialog_seq cop_dialog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .resp_rd(resp_rd), .resp_word(resp_word),
  .save_req(save_req), .save_done(save_done), .rest_req(rest_req), .fmt_err(fmt_err),
  .au_busy(au_busy), .slot_valid(slot_valid), .pend_exc(pend_exc), .handoff(handoff),
  .au_done(au_done), .au_done_exc(au_done_exc)
);

// File: tb/test_cop_dialog_seq.sv
`timescale 1ns/1ps
module test_cop_dialog_seq;
  localparam int         LAT_W = 4;
  localparam logic [7:0] VER   = 8'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_exc = 0, resp_rd = 0, save_req = 0, rest_req = 0;
  logic [LAT_W-1:0] cmd_lat = '0;
  logic [7:0] cmd_vec = '0;
  logic [15:0] rest_fmt = '0;
  logic [15:0] resp_word, save_fmt;
  logic save_done, fmt_err, au_busy, slot_full;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cop_dialog_seq #(.LAT_W(LAT_W), .VERSION(VER)) i_cop_dialog_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_lat(cmd_lat), .cmd_exc(cmd_exc),
    .cmd_vec(cmd_vec), .resp_rd(resp_rd), .resp_word(resp_word), .save_req(save_req),
    .save_done(save_done), .save_fmt(save_fmt), .rest_req(rest_req), .rest_fmt(rest_fmt),
    .fmt_err(fmt_err), .au_busy(au_busy), .slot_full(slot_full)
  );

  function automatic logic [15:0] exp_null(input bit ia);
    return ia ? 16'd1 : 16'd0;
  endfunction
  function automatic logic [15:0] exp_take_mid(input logic [7:0] v);
    return (16'd1 << 14) + (16'h1D << 8) + {8'd0, v};
  endfunction
  function automatic logic [15:0] exp_fmt(input int len);
    return {VER, 8'(len)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic issue(input int lat, input bit exc, input logic [7:0] vec);
    cmd_wr = 1; cmd_lat = LAT_W'(lat); cmd_exc = exc; cmd_vec = vec;
    tick();
    cmd_wr = 0;
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    while (au_busy) begin n++; tick(); end
    chk(req, 16'(n), 16'(exp));
  endtask

  task automatic drain();
    while (au_busy || slot_full) tick();
  endtask

  task automatic restore(input logic [15:0] f);
    rest_req = 1; rest_fmt = f;
    tick();
    rest_req = 0;
  endtask

  task automatic save_now(input string req, input logic [15:0] exp);
    save_req = 1;
    tick();
    save_req = 0;
    chk({req, " save_done"}, {15'd0, save_done}, 16'd1);
    chk({req, " fmt"}, save_fmt, exp);
    tick();
    chk({req, " save_done pulse"}, {15'd0, save_done}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit prev_busy;
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 resp", resp_word, exp_null(1));
    chk("R1 au_busy", {15'd0, au_busy}, 16'd0);
    chk("R1 slot_full", {15'd0, slot_full}, 16'd0);
    chk("R1 fmt_err", {15'd0, fmt_err}, 16'd0);
    chk("R1 save_done", {15'd0, save_done}, 16'd0);
    // R9 null frame before any command
    save_now("R9 null", 16'h0000);

    // R3 R4 R5 single instruction
    issue(5, 0, 8'h00);
    chk("R3 slot_full", {15'd0, slot_full}, 16'd1);
    chk("R5 waiting null", resp_word, exp_null(0));
    tick();
    chk("R4 au_busy after handoff", {15'd0, au_busy}, 16'd1);
    chk("R2 released null", resp_word, exp_null(1));
    measure("R4 latency 5", 5);

    // overlap, repeated null reads, ignored write
    issue(6, 0, 8'h00);
    tick();
    issue(3, 0, 8'h00);
    issue(9, 0, 8'h00);            // R3: ignored, slot already full
    resp_rd = 1;
    while (au_busy) begin
      chk("R5 null during overlap", resp_word, exp_null(0));
      chk("R5 slot held", {15'd0, slot_full}, 16'd1);
      tick();
    end
    resp_rd = 0;
    chk("R4 slot still held at idle", {15'd0, slot_full}, 16'd1);
    tick();
    chk("R4 handoff on first idle", {15'd0, au_busy}, 16'd1);
    measure("R3 second instruction latency 3", 3);
    chk("R3 no third instruction", {15'd0, slot_full}, 16'd0);

    // R6 R7 deferred exception
    issue(3, 1, 8'h34);
    drain();
    chk("R6 pending but no next instruction", resp_word, exp_null(1));
    issue(2, 0, 8'h00);
    chk("R6 take-mid", resp_word, exp_take_mid(8'h34));
    tick(); tick();
    chk("R6 handoff blocked", {15'd0, au_busy}, 16'd0);
    chk("R6 held", {15'd0, slot_full}, 16'd1);
    resp_rd = 1;
    tick();
    resp_rd = 0;
    chk("R7 resp after exception read", resp_word, exp_null(1));
    chk("R7 held discarded", {15'd0, slot_full}, 16'd0);
    tick();
    chk("R7 au stays idle", {15'd0, au_busy}, 16'd0);

    // R8 save while busy
    issue(8, 0, 8'h00);
    tick();
    issue(2, 0, 8'h00);
    save_req = 1;
    prev_busy = au_busy;
    tick();
    save_req = 0;
    while (!save_done) begin
      chk("R8 null while save waits", resp_word, exp_null(0));
      prev_busy = au_busy;
      tick();
    end
    chk("R8 save waited for idle", {15'd0, prev_busy}, 16'd0);
    chk("R9 busy frame", save_fmt, exp_fmt(12));
    chk("R8 handoff blocked at save", {15'd0, slot_full}, 16'd1);
    tick();
    chk("R8 handoff after save", {15'd0, au_busy}, 16'd1);
    measure("R8 post-save latency", 2);
    // R12 busy restore reinstates held instruction
    restore(exp_fmt(12));
    chk("R12 held restored", {15'd0, slot_full}, 16'd1);
    tick();
    chk("R12 handoff follows", {15'd0, au_busy}, 16'd1);
    measure("R12 restored latency", 2);
    save_now("R9 idle", exp_fmt(4));

    // R10 rejected restores
    issue(1, 1, 8'h77);
    drain();
    issue(4, 0, 8'h00);
    restore(16'h3304);
    chk("R10 bad version fmt_err", {15'd0, fmt_err}, 16'd1);
    chk("R10 state unchanged", resp_word, exp_take_mid(8'h77));
    tick();
    chk("R10 fmt_err one cycle", {15'd0, fmt_err}, 16'd0);
    restore({VER, 8'd5});
    chk("R10 bad length fmt_err", {15'd0, fmt_err}, 16'd1);
    restore(16'h0004);
    chk("R10 zero version fmt_err", {15'd0, fmt_err}, 16'd1);
    chk("R10 still take-mid", resp_word, exp_take_mid(8'h77));
    save_now("R9 pending busy frame", exp_fmt(12));
    restore(16'h0000);
    chk("R11 null restore clears", resp_word, exp_null(1));
    chk("R11 slot empty", {15'd0, slot_full}, 16'd0);
    restore(exp_fmt(12));
    chk("R12 pending exception restored", resp_word, exp_take_mid(8'h77));
    resp_rd = 1;
    tick();
    resp_rd = 0;
    chk("R7 cleared after restore", resp_word, exp_null(1));
    restore(16'h0000);
    save_now("R11 null then save", 16'h0000);
    restore(exp_fmt(4));
    chk("R11 idle restore", resp_word, exp_null(1));
    save_now("R11 idle then save", exp_fmt(4));

    // random mix
    for (int i = 0; i < 40; i++) begin
      int lat = $urandom_range(1, 15);
      bit exc = ($urandom % 3) == 0;
      logic [7:0] vec = 8'($urandom);
      issue(lat, exc, vec);
      chk("R3 random slot", {15'd0, slot_full}, 16'd1);
      tick();
      measure("R4 random latency", lat);
      if (exc) begin
        chk("R6 random no dialog", resp_word, exp_null(1));
        issue(1, 0, 8'h00);
        chk("R6 random take-mid", resp_word, exp_take_mid(vec));
        resp_rd = 1;
        tick();
        resp_rd = 0;
        chk("R7 random cleared", resp_word, exp_null(1));
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule